// File: doc/BRIEF.md
# Johnson Decade Counter with Seven-Segment Drive

This block is one decimal digit of a counting display. The count lives in a five-bit twisted-ring register that has ten legal codes, one for each digit from 0 to 9. The register feeds a decoder directly, which produces seven active-high segment drives. There is no binary count in between. A carry-out completes one full period every ten counts, so the next decade can use it as its count clock.

A count event is a rising edge of the combined term `count_clk AND NOT count_hold`. This term is sampled on a fast system clock through a two-stage synchronizer, and an edge detector turns its rising edge into a one-cycle step. Holding `count_hold` high therefore blocks counting. With `count_clk` held high, a falling edge on `count_hold` acts as a negative-edge count input. Ripple blanking suppresses a leading zero and passes the blanking condition on to the next digit. Lamp test lights every segment.

The counter state machine has ten named states, `J_D0` to `J_D9`. On a step it takes the transitions `J_D0→J_D1→…→J_D9→J_D0`. Without a step it stays where it is. From any code outside these ten, a step takes it to `J_D0`. The clear input takes it to `J_D0` asynchronously from any state.

Top module: `decade_seg_counter`

## Requirements
- R1: A high `clear` forces the count to 0 asynchronously and holds it there, overriding every other input; edges seen during clear are discarded.
- R2: With `count_hold` low, a rising edge of `count_clk` advances the count by one; the outputs show the new count by the fourth `sys_clk` rising edge after the input change.
- R3: While `count_hold` is high, `count_clk` edges leave the count unchanged, and so does `count_hold` rising while `count_clk` is high.
- R4: With `count_clk` held high, a falling edge of `count_hold` advances the count by one.
- R5: The count runs through ten Johnson codes in the order 00000, 00001, 00011, 00111, 01111, 11111, 11110, 11100, 11000, 10000 (digits 0 to 9) and wraps from 9 to 0. A step taken from any other code goes to 0.
- R6: `carry_out` is high for counts 0 to 4 and low for counts 5 to 9, so it rises only on the wrap from 9 to 0.
- R7: `seg[0]` to `seg[6]` drive segments a to g, active high. For digits 0 to 9 the patterns, as hex with bit 0 = a, are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F.
- R8: When `blank_in` is high and the count is 0, all segments are off and `blank_out` is high. In every other case `blank_out` is low.
- R9: A high `lamp_test` forces `seg` to 7F, taking priority over blanking and decoding. It does not change the count or `blank_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Fast system clock that samples all controls |
| clear | input | 1 | Asynchronous active-high clear to count 0 |
| count_clk | input | 1 | Count clock, counts on its rising edge |
| count_hold | input | 1 | Clock inhibit; its falling edge counts while count_clk is high |
| blank_in | input | 1 | Ripple-blanking input from the more significant digit |
| lamp_test | input | 1 | Forces all segments on |
| seg | output | 7 | Segment drives, bit 0 = a … bit 6 = g, active high |
| carry_out | output | 1 | High for counts 0–4; clocks the next decade |
| blank_out | output | 1 | Ripple-blanking output to the less significant digit |

## Verification
Two pairs of functions can act in the same cycle. In the first, a count step arrives while lamp test holds every segment on. In the second, a zero count meets both ripple blanking and lamp test together. The random phase drives lamp test, blanking and both count inputs at once. A reference count in the bench gives, for each cycle, the expected segments, carry and blanking output, with lamp test taking precedence. Directed sequences then drop lamp test after several steps under it, which shows that the count behind the forced display kept moving.

// File: rtl/decade_pkg.sv
package decade_pkg;
    localparam int RING_W = 5;
    localparam int SEG_W  = 7;
    localparam int DIGITS = 2 * RING_W;

    typedef enum logic [RING_W-1:0] {
        J_D0 = 5'b00000,
        J_D1 = 5'b00001,
        J_D2 = 5'b00011,
        J_D3 = 5'b00111,
        J_D4 = 5'b01111,
        J_D5 = 5'b11111,
        J_D6 = 5'b11110,
        J_D7 = 5'b11100,
        J_D8 = 5'b11000,
        J_D9 = 5'b10000
    } jstate_t;
endpackage

// File: rtl/event_sync.sv
module event_sync #(
    parameter int STAGES = 2
) (
    input  logic sys_clk,
    input  logic clear,
    input  logic raw_in,
    output logic rise_pulse
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge sys_clk or posedge clear) begin
                if (clear) chain_q <= '0;
                else       chain_q <= raw_in;
            end
        end else begin : g_multi
            always_ff @(posedge sys_clk or posedge clear) begin
                if (clear) chain_q <= '0;
                else       chain_q <= {chain_q[STAGES-2:0], raw_in};
            end
        end
    endgenerate

    always_ff @(posedge sys_clk or posedge clear) begin
        if (clear) last_q <= 1'b0;
        else       last_q <= chain_q[STAGES-1];
    end

    assign rise_pulse = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/johnson_fsm.sv
module johnson_fsm
    import decade_pkg::*;
(
    input  logic    sys_clk,
    input  logic    clear,
    input  logic    step,
    output jstate_t state,
    output logic    carry
);
    jstate_t state_nxt;

    always_ff @(posedge sys_clk or posedge clear) begin
        if (clear) state <= J_D0;
        else       state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        if (step) begin
            unique case (state)
                J_D0:    state_nxt = J_D1;
                J_D1:    state_nxt = J_D2;
                J_D2:    state_nxt = J_D3;
                J_D3:    state_nxt = J_D4;
                J_D4:    state_nxt = J_D5;
                J_D5:    state_nxt = J_D6;
                J_D6:    state_nxt = J_D7;
                J_D7:    state_nxt = J_D8;
                J_D8:    state_nxt = J_D9;
                J_D9:    state_nxt = J_D0;
                default: state_nxt = J_D0;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            J_D0, J_D1, J_D2, J_D3, J_D4: carry = 1'b1;
            default:                      carry = 1'b0;
        endcase
    end
endmodule

// File: rtl/seg_decode.sv
module seg_decode
    import decade_pkg::*;
(
    input  jstate_t          state,
    input  logic             blank_in,
    input  logic             lamp_test,
    output logic [SEG_W-1:0] seg,
    output logic             blank_out
);
    logic [SEG_W-1:0] pattern;
    logic             is_zero;

    always_comb begin
        unique case (state)
            J_D0:    pattern = 7'h3F;
            J_D1:    pattern = 7'h06;
            J_D2:    pattern = 7'h5B;
            J_D3:    pattern = 7'h4F;
            J_D4:    pattern = 7'h66;
            J_D5:    pattern = 7'h6D;
            J_D6:    pattern = 7'h7D;
            J_D7:    pattern = 7'h07;
            J_D8:    pattern = 7'h7F;
            J_D9:    pattern = 7'h6F;
            default: pattern = '0;
        endcase
    end

    assign is_zero   = (state == J_D0);
    assign blank_out = blank_in & is_zero;

    always_comb begin
        if (lamp_test)      seg = '1;
        else if (blank_out) seg = '0;
        else                seg = pattern;
    end
endmodule

// File: rtl/decade_seg_counter.sv
module decade_seg_counter
    import decade_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             sys_clk,
    input  logic             clear,
    input  logic             count_clk,
    input  logic             count_hold,
    input  logic             blank_in,
    input  logic             lamp_test,
    output logic [SEG_W-1:0] seg,
    output logic             carry_out,
    output logic             blank_out
);
    logic    gated_clk;
    logic    count_step;
    jstate_t ring_q;

    assign gated_clk = count_clk & ~count_hold;

    event_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .sys_clk    (sys_clk),
        .clear      (clear),
        .raw_in     (gated_clk),
        .rise_pulse (count_step)
    );

    johnson_fsm u_fsm (
        .sys_clk (sys_clk),
        .clear   (clear),
        .step    (count_step),
        .state   (ring_q),
        .carry   (carry_out)
    );

    seg_decode u_dec (
        .state     (ring_q),
        .blank_in  (blank_in),
        .lamp_test (lamp_test),
        .seg       (seg),
        .blank_out (blank_out)
    );
endmodule

// File: rtl/decade_seg_checker.sv
module decade_seg_checker (
    input logic       sys_clk,
    input logic       clear,
    input logic       step,
    input logic [4:0] ring,
    input logic [6:0] seg,
    input logic       carry_out,
    input logic       blank_out,
    input logic       blank_in,
    input logic       lamp_test
);
    // R1: clear holds the ring at zero
    a_r1_clear_zero: assert property (@(posedge sys_clk)
        clear |-> ring == 5'b00000);

    // R5: only legal Johnson codes ever appear
    a_r5_legal_code: assert property (@(posedge sys_clk) disable iff (clear)
        $countones(ring[4:1] ^ ring[3:0]) <= 1);

    // R2: a step shifts the ring one place with inversion feedback
    a_r2_advance: assert property (@(posedge sys_clk) disable iff (clear)
        step |=> ring == {$past(ring[3:0]), ~$past(ring[4])});

    // R3: without a step the ring does not move
    a_r3_hold: assert property (@(posedge sys_clk) disable iff (clear)
        !step |=> $stable(ring));

    // R6: carry rises only on arrival at zero
    a_r6_carry_wrap: assert property (@(posedge sys_clk) disable iff (clear)
        $rose(carry_out) |-> ring == 5'b00000);

    // R8: blanking output only at zero with blanking input
    a_r8_blank_out: assert property (@(posedge sys_clk) disable iff (clear)
        blank_out |-> (ring == 5'b00000 && blank_in));

    // R9: lamp test lights every segment
    a_r9_lamp_all: assert property (@(posedge sys_clk) disable iff (clear)
        lamp_test |-> seg == 7'h7F);
endmodule

bind decade_seg_counter decade_seg_checker i_chk (
    .sys_clk   (sys_clk),
    .clear     (clear),
    .step      (count_step),
    .ring      (ring_q),
    .seg       (seg),
    .carry_out (carry_out),
    .blank_out (blank_out),
    .blank_in  (blank_in),
    .lamp_test (lamp_test)
);

// File: tb/test_decade_seg_counter.sv
module test_decade_seg_counter;
    localparam int CLK_P = 10;

    logic       sys_clk = 1'b0;
    logic       clear = 1'b0;
    logic       count_clk = 1'b0;
    logic       count_hold = 1'b0;
    logic       blank_in = 1'b0;
    logic       lamp_test = 1'b0;
    logic [6:0] seg;
    logic       carry_out;
    logic       blank_out;

    int  checks = 0;
    int  errors = 0;
    int  model_cnt = 0;
    bit  model_prev = 1'b0;
    bit  done = 1'b0;

    decade_seg_counter i_decade_seg_counter (
        .sys_clk    (sys_clk),
        .clear      (clear),
        .count_clk  (count_clk),
        .count_hold (count_hold),
        .blank_in   (blank_in),
        .lamp_test  (lamp_test),
        .seg        (seg),
        .carry_out  (carry_out),
        .blank_out  (blank_out)
    );

    always #(CLK_P/2) sys_clk = ~sys_clk;

    function automatic logic [6:0] digit_pattern(int d);
        case (d)
            0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;
            3: return 7'h4F;  4: return 7'h66;  5: return 7'h6D;
            6: return 7'h7D;  7: return 7'h07;  8: return 7'h7F;
            default: return 7'h6F;
        endcase
    endfunction

    function automatic logic [6:0] exp_seg(int d, bit bi, bit lt);
        if (lt)                return 7'h7F;
        else if (bi && d == 0) return 7'h00;
        else                   return digit_pattern(d);
    endfunction

    task automatic check(string tag, logic [6:0] act, logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h count=%0d", tag, act, exp, model_cnt);
        end
    endtask

    task automatic check_all(string tag);
        string t;
        t = lamp_test ? "R9" : ((blank_in && model_cnt == 0) ? "R8" : "R7");
        check({tag, " ", t, " seg"}, seg, exp_seg(model_cnt, blank_in, lamp_test));
        check({tag, " R6 carry"}, {6'd0, carry_out}, {6'd0, model_cnt < 5});
        check({tag, " R8 blank_out"}, {6'd0, blank_out},
              {6'd0, blank_in && model_cnt == 0});
    endtask

    task automatic apply(string tag, bit ck, bit inh, bit bi, bit lt);
        bit comb;
        @(negedge sys_clk);
        count_clk = ck; count_hold = inh; blank_in = bi; lamp_test = lt;
        repeat (4) @(posedge sys_clk);
        @(negedge sys_clk);
        comb = ck & ~inh;
        if (comb && !model_prev) model_cnt = (model_cnt + 1) % 10;
        model_prev = comb;
        check_all(tag);
    endtask

    task automatic do_clear();
        @(negedge sys_clk);
        count_clk = 1'b0;
        clear = 1'b1;
        #1;
        model_cnt = 0;
        model_prev = 1'b0;
        check("R1 async clear seg", seg, exp_seg(0, blank_in, lamp_test));
        // edges during clear are discarded
        repeat (2) begin
            @(negedge sys_clk); count_clk = 1'b1;
            @(negedge sys_clk); count_clk = 1'b0;
        end
        repeat (3) @(negedge sys_clk);
        check("R1 held during clear", seg, exp_seg(0, blank_in, lamp_test));
        clear = 1'b0;
        repeat (4) @(negedge sys_clk);
        check_all("R1 after release");
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        #2 clear = 1'b1;
        repeat (3) @(negedge sys_clk);
        check("R1 reset seg", seg, 7'h3F);
        check("R1 reset carry", {6'd0, carry_out}, 7'd1);
        clear = 1'b0;
        repeat (3) @(negedge sys_clk);

        // R2 R5 R6 R7: full cycle plus wrap
        for (int i = 0; i < 12; i++) begin
            apply("R2 R5 step", 1'b1, 1'b0, 1'b0, 1'b0);
            apply("R2 low", 1'b0, 1'b0, 1'b0, 1'b0);
        end
        // R3: inhibit high blocks clock edges
        apply("R3 hold set", 1'b0, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) begin
            apply("R3 blocked rise", 1'b1, 1'b1, 1'b0, 1'b0);
            apply("R3 blocked fall", 1'b0, 1'b1, 1'b0, 1'b0);
        end
        // R4: clock high, inhibit falling counts
        apply("R4 clk high", 1'b1, 1'b1, 1'b0, 1'b0);
        apply("R4 hold fall", 1'b1, 1'b0, 1'b0, 1'b0);
        apply("R3 hold rise", 1'b1, 1'b1, 1'b0, 1'b0);
        apply("R4 hold fall", 1'b1, 1'b0, 1'b0, 1'b0);
        apply("R2 low", 1'b0, 1'b0, 1'b0, 1'b0);

        // R8 R9: blanking and lamp test at zero
        do_clear();
        apply("R8 blank zero", 1'b0, 1'b0, 1'b1, 1'b0);
        apply("R9 lamp over blank", 1'b0, 1'b0, 1'b1, 1'b1);
        // R9: counting continues under lamp test
        for (int i = 0; i < 3; i++) begin
            apply("R9 step under lamp", 1'b1, 1'b0, 1'b1, 1'b1);
            apply("R9 low under lamp", 1'b0, 1'b0, 1'b1, 1'b1);
        end
        apply("R9 lamp off shows count", 1'b0, 1'b0, 1'b1, 1'b0);
        apply("R8 nonzero no blank", 1'b0, 1'b0, 1'b1, 1'b0);

        // R1: clear in mid count
        apply("R2 step", 1'b1, 1'b0, 1'b0, 1'b0);
        do_clear();

        // random mix
        for (int i = 0; i < 600; i++) begin
            bit ck, inh, bi, lt;
            ck  = 1'($urandom % 2);
            inh = ($urandom % 4) == 0;
            bi  = 1'($urandom % 2);
            lt  = ($urandom % 5) == 0;
            if (($urandom % 60) == 0) do_clear();
            else apply("R2 R3 random", ck, inh, bi, lt);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule